// File: doc/BRIEF.md
# Prefix-to-Bypass Mode Switch Controller

This controller follows the bins of a motion-vector-difference or coefficient-magnitude syntax element as a multi-bin arithmetic decoder produces them. The decoder delivers up to `LANES` bins per cycle. A start pulse opens an element and records its type. The controller keeps the decoder in context-coded (decision) mode while the unary prefix runs. When the first 0 bin ends the prefix, the controller works out how many bypass bins must follow and switches the mode select from the next cycle on. Any lanes decoded in that same cycle after the terminating 0 are flagged as discarded. It then counts the bypass bins down and pulses done when the last one, which is the sign bin, is accepted.

Bins arrive on a lane-parallel valid/ready stream. `in_ready` is high while an element is open. A lane transfers when `in_ready` and its `lane_vld` bit are both high and its `kill_mask` bit is low. Valid lanes must be contiguous from lane 0, and lane i carries bin index `in_idx + i`. The producer may hold all lanes invalid for any number of cycles, and this is the only form of back-pressure. While `in_ready` is low, offered bins are not consumed and have no effect.

Top module: `bpsw_ctrl`

## Requirements
- R1: After reset, `in_ready`, `byp_mode` and `elem_done` are 0, `byp_left` is 0 and `kill_mask` is 0.
- R2: A start pulse while idle latches `elem_type` (0 = motion-vector difference, 1 = coefficient magnitude). From the next cycle on, `in_ready` is 1, `byp_mode` is 0 (decision) and `byp_left` is 0.
- R3: If the terminating 0 bin sits at index t with t+1 not above the element's boundary, exactly one bypass bin (the sign) follows, so `byp_left` becomes 1.
- R4: For a motion-vector difference, the boundary is 8. With t+1 = 8+n and n > 0, `byp_left` becomes n+2.
- R5: For a coefficient magnitude, the boundary is 13. With t+1 = 13+n and n > 0, `byp_left` becomes n.
- R6: `byp_mode` rises in the cycle after the one that accepts the terminating 0, and stays 0 in earlier prefix cycles, including cycles with no valid lane. In the terminating cycle, `kill_mask` bit i is 1 exactly for valid lanes above the terminating lane.
- R7: In bypass mode, each accepted lane lowers `byp_left` by one. Valid lanes i with i >= `byp_left` are flagged in `kill_mask`.
- R8: `elem_done` is high, combinationally, in the cycle that accepts the final bypass bin. In the next cycle the block is idle again: `in_ready`, `byp_mode` and `byp_left` are all 0.
- R9: A start pulse while an element is open has no effect.
- R10: The bypass count saturates at 31 (5-bit counter).
- R11: While idle, offered bins produce no kill flag and no done pulse, and leave the block idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Opens an element when idle |
| elem_type | input | 1 | 0 motion-vector difference, 1 coefficient magnitude |
| in_idx | input | IDXW | Bin index of lane 0 |
| lane_vld | input | LANES | Per-lane valid, contiguous from lane 0 |
| lane_bin | input | LANES | Per-lane decoded bin value |
| in_ready | output | 1 | Element open; lanes may transfer |
| byp_mode | output | 1 | Mode for this cycle: 1 bypass, 0 decision |
| byp_left | output | CNTW | Bypass bins still to be accepted |
| kill_mask | output | LANES | Lanes whose bins are discarded |
| elem_done | output | 1 | Final bypass bin accepted this cycle |

## Verification
Two things share one cycle here: the prefix-terminating 0 and the discarding of the lanes decoded after it, where the mode change itself lands one cycle later. The bench provokes this by sweeping the terminating index over every lane position with one, two and three lanes per cycle, and fills the later lanes with 1 bins. It judges the kill mask in the same cycle and the mode and bypass count in the next. The same overlap arises in bypass mode, where the last accepted bin, the done pulse and the killing of surplus lanes coincide. This is swept over every remaining count against every lane width.

// File: rtl/bpsw_pkg.sv
package bpsw_pkg;
  typedef enum logic {
    ELEM_MVD   = 1'b0,
    ELEM_COEFF = 1'b1
  } elem_e;
endpackage

// File: rtl/bpsw_prefix_scan.sv
module bpsw_prefix_scan #(
  parameter int LANES = 3,
  parameter int IDXW  = 6
) (
  input  logic [LANES-1:0] lane_vld,
  input  logic [LANES-1:0] lane_bin,
  input  logic [IDXW-1:0]  base_idx,
  output logic             hit,
  output logic [IDXW-1:0]  term_idx,
  output logic [LANES-1:0] kill
);
  // First valid 0 ends the prefix; later valid lanes are discarded.
  always_comb begin
    hit      = 1'b0;
    term_idx = '0;
    kill     = '0;
    for (int i = 0; i < LANES; i++) begin
      if (lane_vld[i]) begin
        if (hit) begin
          kill[i] = 1'b1;
        end else if (!lane_bin[i]) begin
          hit      = 1'b1;
          term_idx = base_idx + IDXW'(i);
        end
      end
    end
  end
endmodule

// File: rtl/bpsw_len_calc.sv
module bpsw_len_calc #(
  parameter int IDXW        = 6,
  parameter int CNTW        = 5,
  parameter int MVD_BOUND   = 8,
  parameter int COEFF_BOUND = 13,
  parameter int MVD_EXTRA   = 2
) (
  input  logic            elem,
  input  logic [IDXW-1:0] term_idx,
  output logic [CNTW-1:0] len
);
  localparam int SW = IDXW + 2;
  localparam logic [SW-1:0] MAXC = SW'((1 << CNTW) - 1);

  logic [SW-1:0] total, bound, extra, raw;

  always_comb begin
    total = SW'(term_idx) + SW'(1);
    bound = elem ? SW'(COEFF_BOUND) : SW'(MVD_BOUND);
    extra = elem ? '0 : SW'(MVD_EXTRA);
    if (total <= bound) raw = SW'(1);
    else                raw = total - bound + extra;
    len = (raw > MAXC) ? MAXC[CNTW-1:0] : raw[CNTW-1:0];
  end
endmodule

// File: rtl/bpsw_bypass_trim.sv
module bpsw_bypass_trim #(
  parameter int LANES = 3,
  parameter int CNTW  = 5
) (
  input  logic [LANES-1:0] lane_vld,
  input  logic [CNTW-1:0]  left,
  output logic [LANES-1:0] kill,
  output logic [CNTW-1:0]  take,
  output logic             last
);
  always_comb begin
    kill = '0;
    take = '0;
    for (int i = 0; i < LANES; i++) begin
      if (lane_vld[i]) begin
        if (CNTW'(i) >= left) kill[i] = 1'b1;
        else                  take    = take + CNTW'(1);
      end
    end
    last = (left != '0) && (take == left);
  end
endmodule

// File: rtl/bpsw_ctrl.sv
module bpsw_ctrl #(
  parameter int LANES       = 3,
  parameter int IDXW        = 6,
  parameter int CNTW        = 5,
  parameter int MVD_BOUND   = 8,
  parameter int COEFF_BOUND = 13,
  parameter int MVD_EXTRA   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             elem_type,
  input  logic [IDXW-1:0]  in_idx,
  input  logic [LANES-1:0] lane_vld,
  input  logic [LANES-1:0] lane_bin,
  output logic             in_ready,
  output logic             byp_mode,
  output logic [CNTW-1:0]  byp_left,
  output logic [LANES-1:0] kill_mask,
  output logic             elem_done
);
  import bpsw_pkg::*;

  logic             active_q, byp_q;
  logic [CNTW-1:0]  left_q;
  elem_e            elem_q;

  logic [LANES-1:0] vld_g;
  logic             hit;
  logic [IDXW-1:0]  term_idx;
  logic [LANES-1:0] pre_kill, byp_kill;
  logic [CNTW-1:0]  len, take;
  logic             last;

  assign vld_g = lane_vld & {LANES{active_q}};

  bpsw_prefix_scan #(.LANES(LANES), .IDXW(IDXW)) u_scan (
    .lane_vld (vld_g & {LANES{~byp_q}}),
    .lane_bin (lane_bin),
    .base_idx (in_idx),
    .hit      (hit),
    .term_idx (term_idx),
    .kill     (pre_kill)
  );

  bpsw_len_calc #(
    .IDXW(IDXW), .CNTW(CNTW), .MVD_BOUND(MVD_BOUND),
    .COEFF_BOUND(COEFF_BOUND), .MVD_EXTRA(MVD_EXTRA)
  ) u_len (
    .elem     (elem_q == ELEM_COEFF),
    .term_idx (term_idx),
    .len      (len)
  );

  bpsw_bypass_trim #(.LANES(LANES), .CNTW(CNTW)) u_trim (
    .lane_vld (vld_g & {LANES{byp_q}}),
    .left     (left_q),
    .kill     (byp_kill),
    .take     (take),
    .last     (last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      byp_q    <= 1'b0;
      left_q   <= '0;
      elem_q   <= ELEM_MVD;
    end else if (!active_q) begin
      if (start) begin
        active_q <= 1'b1;
        byp_q    <= 1'b0;
        left_q   <= '0;
        elem_q   <= elem_e'(elem_type);
      end
    end else if (!byp_q) begin
      if (hit) begin
        byp_q  <= 1'b1;
        left_q <= len;
      end
    end else if (last) begin
      active_q <= 1'b0;
      byp_q    <= 1'b0;
      left_q   <= '0;
    end else begin
      left_q <= left_q - take;
    end
  end

  assign in_ready  = active_q;
  assign byp_mode  = byp_q;
  assign byp_left  = left_q;
  assign kill_mask = byp_q ? byp_kill : pre_kill;
  assign elem_done = active_q & byp_q & last;
endmodule

// File: rtl/bpsw_checker.sv
module bpsw_checker #(
  parameter int LANES = 3,
  parameter int CNTW  = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [LANES-1:0] lane_vld,
  input logic [LANES-1:0] lane_bin,
  input logic             in_ready,
  input logic             byp_mode,
  input logic [CNTW-1:0]  byp_left,
  input logic [LANES-1:0] kill_mask,
  input logic             elem_done
);
  p_start_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && start) |=> (in_ready && !byp_mode && byp_left == '0));

  p_switch_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !byp_mode && ((lane_vld & ~lane_bin) != '0)) |=> (byp_mode && byp_left != '0));

  p_kill_valid_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((kill_mask & ~lane_vld) == '0));

  p_left_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
    byp_mode |-> (byp_left != '0));

  p_count_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && byp_mode && lane_vld[0] && !elem_done) |=> (byp_left < $past(byp_left)));

  p_done_closes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    elem_done |=> (!in_ready && !byp_mode && byp_left == '0));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> (kill_mask == '0 && !elem_done && !byp_mode));
endmodule

bind bpsw_ctrl bpsw_checker #(.LANES(LANES), .CNTW(CNTW)) u_bpsw_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .lane_vld  (lane_vld),
  .lane_bin  (lane_bin),
  .in_ready  (in_ready),
  .byp_mode  (byp_mode),
  .byp_left  (byp_left),
  .kill_mask (kill_mask),
  .elem_done (elem_done)
);

// File: tb/test_bpsw_ctrl.sv
module test_bpsw_ctrl;
  localparam int LANES = 3;
  localparam int IDXW  = 6;
  localparam int CNTW  = 5;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic             elem_type = 1'b0;
  logic [IDXW-1:0]  in_idx = '0;
  logic [LANES-1:0] lane_vld = '0;
  logic [LANES-1:0] lane_bin = '0;
  logic             in_ready, byp_mode, elem_done;
  logic [CNTW-1:0]  byp_left;
  logic [LANES-1:0] kill_mask;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  bpsw_ctrl #(.LANES(LANES), .IDXW(IDXW), .CNTW(CNTW)) i_bpsw_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .elem_type(elem_type),
    .in_idx(in_idx), .lane_vld(lane_vld), .lane_bin(lane_bin),
    .in_ready(in_ready), .byp_mode(byp_mode), .byp_left(byp_left),
    .kill_mask(kill_mask), .elem_done(elem_done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_len(input int el, input int t);
    int total = t + 1;
    int b = el ? 13 : 8;
    int v;
    if (total <= b) return 1;
    v = total - b + (el ? 0 : 2);
    return (v > 31) ? 31 : v;
  endfunction

  function automatic string len_req(input int el, input int t);
    int v = t + 1 - (el ? 13 : 8) + (el ? 0 : 2);
    if (t + 1 <= (el ? 13 : 8)) return "R3";
    if (v > 31) return "R10";
    return el ? "R5" : "R4";
  endfunction

  task automatic run_case(input int el, input int t, input int w);
    int idx = 0;
    bit stalled = 1'b0;
    int e, rem;
    @(negedge clk);
    start = 1'b1; elem_type = el[0]; lane_vld = '0;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    chk(in_ready && !byp_mode && byp_left == 0, "R2", int'({in_ready, byp_mode}), 2);
    while (idx <= t) begin
      if (w == 1 && idx == 1 && !stalled) begin
        lane_vld = '0; #1;
        chk(kill_mask == 0, "R6", int'(kill_mask), 0);
        @(posedge clk); @(negedge clk);
        chk(!byp_mode, "R6", int'(byp_mode), 0);
        stalled = 1'b1;
        continue;
      end
      begin
        logic [LANES-1:0] ek = '0;
        in_idx = IDXW'(idx);
        for (int i = 0; i < LANES; i++) begin
          lane_vld[i] = (i < w);
          lane_bin[i] = (idx + i != t);
          ek[i] = (i < w) && (idx + i > t);
        end
        start = (idx == 0 && w == 2);   // R9: start while open
        #1;
        chk(kill_mask == ek, "R6", int'(kill_mask), int'(ek));
        chk(!elem_done, "R6", int'(elem_done), 0);
      end
      @(posedge clk); @(negedge clk);
      start = 1'b0; lane_vld = '0;
      idx += w;
      if (idx <= t) chk(!byp_mode && in_ready, "R9", int'(byp_mode), 0);
    end
    e = exp_len(el, t);
    chk(byp_mode, "R6", int'(byp_mode), 1);
    chk(int'(byp_left) == e, len_req(el, t), int'(byp_left), e);
    rem = e;
    while (rem > 0) begin
      logic [LANES-1:0] ek = '0;
      for (int i = 0; i < LANES; i++) begin
        lane_vld[i] = (i < w);
        lane_bin[i] = i[0];
        ek[i] = (i < w) && (i >= rem);
      end
      start = (w == 3 && rem == e);     // R9: start in bypass
      #1;
      chk(kill_mask == ek, "R7", int'(kill_mask), int'(ek));
      chk(elem_done == (w >= rem), "R8", int'(elem_done), int'(w >= rem));
      @(posedge clk); @(negedge clk);
      start = 1'b0; lane_vld = '0;
      rem -= (w < rem) ? w : rem;
      if (rem > 0) chk(byp_mode && int'(byp_left) == rem, "R7", int'(byp_left), rem);
      else chk(!in_ready && !byp_mode && byp_left == 0, "R8", int'({in_ready, byp_mode}), 0);
    end
    lane_vld = '1; lane_bin = '0; #1;
    chk(kill_mask == 0 && !elem_done, "R11", int'(kill_mask), 0);
    @(posedge clk); @(negedge clk);
    lane_vld = '0;
    chk(!in_ready && byp_left == 0, "R11", int'(in_ready), 0);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!in_ready && !byp_mode && byp_left == 0 && kill_mask == 0 && !elem_done,
        "R1", int'(in_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!in_ready, "R1", int'(in_ready), 0);
    for (int el = 0; el < 2; el++)
      for (int t = 0; t <= 40; t++)
        for (int w = 1; w <= LANES; w++)
          run_case(el, t, w);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule